// File: doc/BRIEF.md
# Receive FIFO Controller with Trigger Level and Character Timeout

This block holds received bytes for a 16550-style serial port. A deserializer hands it bytes with a push strobe, and a break detector hands it break events. The host side reads bytes out one at a time, reads the line status to acknowledge break and overrun, and writes an 8-bit FIFO control word. The control word turns the FIFO on or off, flushes the receive store, asks for a transmit-store flush, and selects a receive trigger threshold. The transmit flush is only passed on as a one-cycle pulse.

The block reports its fill level, a trigger comparison that an interrupt encoder can use, and the data-ready, break and overrun flags. It also keeps a character-timeout pending flag. An idle timer runs on a character-time tick supplied by the baud generator, and it restarts whenever data arrives or a read leaves data behind. If four character times pass with bytes still waiting, the pending flag is raised, so software learns of a partly filled FIFO that never reaches the threshold.

The idle timer is a two-state machine. In state TM_IDLE it does not count. It moves from TM_IDLE to TM_COUNT on a restart, which loads the count of four. On each tick in TM_COUNT the count steps down, and when the tick arrives with one remaining the timer goes back to TM_IDLE. There are two more ways from TM_COUNT to TM_IDLE: a read that empties the store, and a receive flush or disabled FIFO.

Top module: `rx_fifo_ctrl`

## Requirements
- R1: With the FIFO enabled the store holds 16 bytes and returns them oldest first. `rd_data` shows the oldest byte during the cycle `rd_strobe` is high. A read of an empty store returns 0x00 and changes no state.
- R2: A control write keeps only bits 7, 6, 3 and 0 in `fcr_q`, and the other bits read back as 0. Bit 0 is the enable. `dma_mode` follows bit 3. `iir_fifo_bits` is 2'b11 while bit 0 is set and 2'b00 otherwise.
- R3: A control write with bit 1 set empties the receive store. It also clears data-ready, break, overrun and timeout-pending.
- R4: A control write whose bit 0 differs from the stored enable performs both flushes. `tx_rst_pulse` is high for exactly the one cycle after any write that has bit 2 set or toggles the enable. A transmit flush leaves the receive store untouched.
- R5: With the FIFO enabled, `trig_hit` is high when the fill level is at least 1, 4, 8 or 14, for bits 7:6 equal to 00, 01, 10 or 11. With the FIFO disabled, `trig_hit` equals `data_ready`.
- R6: With the FIFO disabled the store holds a single byte.
- R7: `data_ready` is set by an accepted byte and cleared by the read that empties the store. It always equals level nonzero.
- R8: A break event enters a 0x00 byte and sets the break and data-ready flags. The break flag is cleared by a line-status read or by the read that empties the store.
- R9: A byte pushed into a full store is dropped and sets `overrun`. A line-status read clears `overrun`.
- R10: An accepted data push, or a read that leaves data behind, loads four character times. A tick in that same cycle is not counted. `timeout_pend` rises right after the fourth following tick if the store still holds data.
- R11: `timeout_pend` is cleared by any data read, including a read of an empty store, and by a receive flush. While the FIFO is disabled the timer holds and never raises the flag.
- R12: A read that empties the store stops the timer, so no timeout follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Received byte strobe |
| push_data | input | 8 | Received byte |
| brk_event | input | 1 | Break detected strobe |
| rd_strobe | input | 1 | Host data read |
| rd_data | output | 8 | Oldest byte, or 0x00 when empty |
| lsr_rd | input | 1 | Host line-status read |
| fcr_wr | input | 1 | Control word write strobe |
| fcr_wdata | input | 8 | Control word |
| char_tick | input | 1 | One pulse per character time |
| fcr_q | output | 8 | Retained control bits |
| iir_fifo_bits | output | 2 | FIFO-enabled field for the identification register |
| dma_mode | output | 1 | Retained DMA select bit |
| tx_rst_pulse | output | 1 | Transmit store flush strobe |
| level | output | 5 | Bytes held |
| trig_hit | output | 1 | Threshold reached |
| data_ready | output | 1 | Data-ready flag |
| brk_flag | output | 1 | Break flag |
| overrun | output | 1 | Overrun flag |
| timeout_pend | output | 1 | Character timeout pending |

## Verification
The trigger comparison is swept over every threshold code and every fill level from 0 to 16. This separates the four thresholds from each other and exposes off-by-one compares. Byte order is checked with a fill of distinct arithmetic values, which tells a correct wrap from a swapped head and tail. The timeout is tried with 0 to 5 ticks after a push, and with restarts from a second push, a partial read and a push that coincides with a tick. These cases separate the expiry count, the restart sources and the cases where the timer must stop. The single-byte disabled mode, the break byte and the flush strobes are each checked at the ports before and after the relevant write or read.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int FCR_EN_BIT    = 0;
    localparam int FCR_RXCLR_BIT = 1;
    localparam int FCR_TXCLR_BIT = 2;
    localparam int FCR_DMA_BIT   = 3;
    localparam logic [7:0] FCR_KEEP_MASK = 8'hC9;

    typedef enum logic [0:0] {
        TM_IDLE  = 1'b0,
        TM_COUNT = 1'b1
    } tm_state_e;

    // Threshold for a 2-bit code, scaled to the store depth.
    function automatic int unsigned trig_threshold(input logic [1:0] code,
                                                   input int unsigned depth);
        int unsigned thr;
        unique case (code)
            2'b00:   thr = 1;
            2'b01:   thr = depth / 4;
            2'b10:   thr = depth / 2;
            default: thr = depth - 2;
        endcase
        return thr;
    endfunction

endpackage

// File: rtl/rxf_fcr_ctl.sv
module rxf_fcr_ctl
    import rxf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fcr_wr,
    input  logic [7:0] fcr_wdata,
    output logic [7:0] fcr_q,
    output logic       rx_clr,
    output logic       tx_rst_pulse
);

    logic en_toggle;
    logic tx_clr_req;

    assign en_toggle  = fcr_wr && (fcr_wdata[FCR_EN_BIT] != fcr_q[FCR_EN_BIT]);
    assign rx_clr     = (fcr_wr && fcr_wdata[FCR_RXCLR_BIT]) || en_toggle;
    assign tx_clr_req = (fcr_wr && fcr_wdata[FCR_TXCLR_BIT]) || en_toggle;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fcr_q        <= '0;
            tx_rst_pulse <= 1'b0;
        end else begin
            tx_rst_pulse <= tx_clr_req;
            if (fcr_wr) begin
                fcr_q <= fcr_wdata & FCR_KEEP_MASK;
            end
        end
    end

endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          cap_one,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          wr_ok,
    output logic          rd_ok
);

    logic [AW-1:0] head_q;
    logic [AW-1:0] tail_q;
    logic [DW-1:0] mem [DEPTH];

    assign full  = cap_one ? (level != '0) : (level == CW'(DEPTH));
    assign wr_ok = wr_en && !full && !clr;
    assign rd_ok = rd_en && (level != '0) && !clr;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [DW-1:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr_ok && (head_q == AW'(i))) begin
                slot_q <= wr_data;
            end
        end
        assign mem[i] = slot_q;
    end

    assign rd_data = (level == '0) ? '0 : mem[tail_q];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            level  <= '0;
        end else if (clr) begin
            head_q <= '0;
            tail_q <= '0;
            level  <= '0;
        end else begin
            if (wr_ok) head_q <= bump(head_q);
            if (rd_ok) tail_q <= bump(tail_q);
            unique case ({wr_ok, rd_ok})
                2'b10:   level <= level + CW'(1);
                2'b01:   level <= level - CW'(1);
                default: level <= level;
            endcase
        end
    end

    // R1
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    // R6
    single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_one && !wr_ok && !rd_ok && level <= CW'(1) |=> level <= CW'(1));

endmodule

// File: rtl/rxf_status.sv
module rxf_status (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic byte_in,
    input  logic brk_in,
    input  logic drop,
    input  logic rd_empties,
    input  logic lsr_rd,
    output logic dr_q,
    output logic brk_q,
    output logic ovr_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dr_q  <= 1'b0;
            brk_q <= 1'b0;
            ovr_q <= 1'b0;
        end else if (clr) begin
            dr_q  <= 1'b0;
            brk_q <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            if (byte_in)         dr_q <= 1'b1;
            else if (rd_empties) dr_q <= 1'b0;

            if (brk_in)                    brk_q <= 1'b1;
            else if (lsr_rd || rd_empties) brk_q <= 1'b0;

            if (drop)        ovr_q <= 1'b1;
            else if (lsr_rd) ovr_q <= 1'b0;
        end
    end

    // R9
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop && !clr |=> ovr_q);

    // R8
    brk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_in && !clr |=> brk_q);

endmodule

// File: rtl/rxf_timeout.sv
module rxf_timeout
    import rxf_pkg::*;
#(
    parameter int TO_CHARS = 4,
    localparam int TW      = $clog2(TO_CHARS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic clr,
    input  logic restart,
    input  logic stop,
    input  logic rd_any,
    input  logic tick,
    input  logic level_nz,
    output logic pend
);

    tm_state_e     st_q, st_d;
    logic [TW-1:0] cnt_q, cnt_d;
    logic          pend_q, pend_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= TM_IDLE;
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            pend_q <= pend_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        pend_d = pend_q;
        if (clr || !enable) begin
            st_d   = TM_IDLE;
            cnt_d  = '0;
            pend_d = 1'b0;
        end else begin
            if (rd_any) pend_d = 1'b0;
            if (restart) begin
                st_d  = TM_COUNT;
                cnt_d = TW'(TO_CHARS);
            end else if (stop) begin
                st_d  = TM_IDLE;
                cnt_d = '0;
            end else begin
                unique case (st_q)
                    TM_IDLE: begin
                        cnt_d = '0;
                    end
                    TM_COUNT: begin
                        if (tick) begin
                            if (cnt_q == TW'(1)) begin
                                st_d  = TM_IDLE;
                                cnt_d = '0;
                                if (level_nz) pend_d = 1'b1;
                            end else begin
                                cnt_d = cnt_q - TW'(1);
                            end
                        end
                    end
                    default: begin
                        st_d = TM_IDLE;
                    end
                endcase
            end
        end
    end

    assign pend = pend_q;

    // R10
    pend_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q ##1 pend_q |-> $past(tick));

    // R11
    pend_rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_any |=> !pend_q);

    // R11
    pend_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !pend_q && st_q == TM_IDLE);

endmodule

// File: rtl/rx_fifo_ctrl.sv
module rx_fifo_ctrl
    import rxf_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int TO_CHARS = 4,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic [7:0]    push_data,
    input  logic          brk_event,
    input  logic          rd_strobe,
    output logic [7:0]    rd_data,
    input  logic          lsr_rd,
    input  logic          fcr_wr,
    input  logic [7:0]    fcr_wdata,
    input  logic          char_tick,
    output logic [7:0]    fcr_q,
    output logic [1:0]    iir_fifo_bits,
    output logic          dma_mode,
    output logic          tx_rst_pulse,
    output logic [CW-1:0] level,
    output logic          trig_hit,
    output logic          data_ready,
    output logic          brk_flag,
    output logic          overrun,
    output logic          timeout_pend
);

    logic          rx_clr;
    logic          fifo_en;
    logic          push_req;
    logic [7:0]    push_byte;
    logic          full;
    logic          wr_ok;
    logic          rd_ok;
    logic          rd_empties;
    logic          drop;
    logic          restart;
    logic [CW-1:0] thr;

    rxf_fcr_ctl u_fcr (
        .clk          (clk),
        .rst_n        (rst_n),
        .fcr_wr       (fcr_wr),
        .fcr_wdata    (fcr_wdata),
        .fcr_q        (fcr_q),
        .rx_clr       (rx_clr),
        .tx_rst_pulse (tx_rst_pulse)
    );

    assign fifo_en       = fcr_q[FCR_EN_BIT];
    assign dma_mode      = fcr_q[FCR_DMA_BIT];
    assign iir_fifo_bits = {2{fifo_en}};

    assign push_req  = push_valid || brk_event;
    assign push_byte = brk_event ? 8'h00 : push_data;

    rxf_store #(.DEPTH(DEPTH), .DW(8)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (rx_clr),
        .cap_one (!fifo_en),
        .wr_en   (push_req),
        .wr_data (push_byte),
        .rd_en   (rd_strobe),
        .rd_data (rd_data),
        .level   (level),
        .full    (full),
        .wr_ok   (wr_ok),
        .rd_ok   (rd_ok)
    );

    assign rd_empties = rd_ok && !wr_ok && (level == CW'(1));
    assign drop       = push_req && full && !rx_clr;
    assign restart    = (wr_ok && !brk_event) || (rd_ok && !rd_empties);

    rxf_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (rx_clr),
        .byte_in    (wr_ok),
        .brk_in     (brk_event && !rx_clr),
        .drop       (drop),
        .rd_empties (rd_empties),
        .lsr_rd     (lsr_rd),
        .dr_q       (data_ready),
        .brk_q      (brk_flag),
        .ovr_q      (overrun)
    );

    rxf_timeout #(.TO_CHARS(TO_CHARS)) u_timeout (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (fifo_en),
        .clr      (rx_clr),
        .restart  (restart),
        .stop     (rd_empties),
        .rd_any   (rd_strobe),
        .tick     (char_tick),
        .level_nz (level != '0),
        .pend     (timeout_pend)
    );

    assign thr      = CW'(trig_threshold(fcr_q[7:6], DEPTH));
    assign trig_hit = fifo_en ? (level >= thr) : data_ready;

    // R7
    dr_level_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready == (level != '0));

    // R3
    rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clr |=> level == '0 && !timeout_pend && !overrun);

    // R4
    toggle_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fcr_wr && (fcr_wdata[FCR_EN_BIT] != fcr_q[FCR_EN_BIT]) |=> level == '0 && tx_rst_pulse);

endmodule

// File: tb/tb_rx_fifo_ctrl.sv
module tb_rx_fifo_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = '0;
    logic       brk_event = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rd_data;
    logic       lsr_rd = 1'b0;
    logic       fcr_wr = 1'b0;
    logic [7:0] fcr_wdata = '0;
    logic       char_tick = 1'b0;
    logic [7:0] fcr_q;
    logic [1:0] iir_fifo_bits;
    logic       dma_mode;
    logic       tx_rst_pulse;
    logic [4:0] level;
    logic       trig_hit;
    logic       data_ready;
    logic       brk_flag;
    logic       overrun;
    logic       timeout_pend;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    rx_fifo_ctrl dut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
        .brk_event(brk_event), .rd_strobe(rd_strobe), .rd_data(rd_data),
        .lsr_rd(lsr_rd), .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata),
        .char_tick(char_tick), .fcr_q(fcr_q), .iir_fifo_bits(iir_fifo_bits),
        .dma_mode(dma_mode), .tx_rst_pulse(tx_rst_pulse), .level(level),
        .trig_hit(trig_hit), .data_ready(data_ready), .brk_flag(brk_flag),
        .overrun(overrun), .timeout_pend(timeout_pend)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            finish_run();
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [7:0] b);
        push_valid = 1'b1; push_data = b;
        step();
        push_valid = 1'b0;
    endtask

    task automatic push_tick(input logic [7:0] b);
        push_valid = 1'b1; push_data = b; char_tick = 1'b1;
        step();
        push_valid = 1'b0; char_tick = 1'b0;
    endtask

    task automatic rd(output logic [7:0] got);
        rd_strobe = 1'b1;
        #1 got = rd_data;
        step();
        rd_strobe = 1'b0;
    endtask

    task automatic fcr_write(input logic [7:0] v);
        fcr_wr = 1'b1; fcr_wdata = v;
        step();
        fcr_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            char_tick = 1'b1;
            step();
            char_tick = 1'b0;
        end
    endtask

    task automatic do_lsr();
        lsr_rd = 1'b1;
        step();
        lsr_rd = 1'b0;
    endtask

    function automatic int thr_of(input int code);
        case (code)
            0: return 1;
            1: return DEPTH / 4;
            2: return DEPTH / 2;
            default: return DEPTH - 2;
        endcase
    endfunction

    initial begin
        logic [7:0] got;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();

        // Reset state
        check("R2 reset fcr", fcr_q, 0);
        check("R2 reset iir bits", iir_fifo_bits, 0);
        check("R1 reset level", level, 0);
        check("R7 reset data_ready", data_ready, 0);
        check("R8 reset brk", brk_flag, 0);
        check("R9 reset overrun", overrun, 0);
        check("R10 reset pend", timeout_pend, 0);

        // R2 / R4: retained bits, iir field, tx strobe
        fcr_write(8'hFF);
        check("R2 fcr mask", fcr_q, 8'hC9);
        check("R2 iir bits on", iir_fifo_bits, 3);
        check("R2 dma", dma_mode, 1);
        check("R4 tx pulse", tx_rst_pulse, 1);
        step();
        check("R4 tx pulse one cycle", tx_rst_pulse, 0);
        fcr_write(8'h01);
        check("R2 fcr 01", fcr_q, 8'h01);
        check("R4 no tx pulse", tx_rst_pulse, 0);

        // R1 / R9: fill, overflow, drain in order
        for (int i = 0; i < DEPTH; i++) push(8'((i * 29 + 3) & 8'hFF));
        check("R1 level full", level, DEPTH);
        push(8'hEE);
        check("R9 overrun set", overrun, 1);
        check("R9 level kept", level, DEPTH);
        do_lsr();
        check("R9 overrun cleared", overrun, 0);
        for (int i = 0; i < DEPTH; i++) begin
            rd(got);
            check("R1 order", got, (i * 29 + 3) & 8'hFF);
        end
        check("R7 dr cleared on empty", data_ready, 0);
        rd(got);
        check("R1 empty read zero", got, 0);
        check("R1 empty read level", level, 0);

        // R5 sweep over codes and levels; R3 flush
        for (int code = 0; code < 4; code++) begin
            fcr_write(8'((code << 6) | 3));
            check("R3 flush level", level, 0);
            for (int n = 0; n <= DEPTH; n++) begin
                check($sformatf("R5 trig code %0d lvl %0d", code, n), trig_hit, (n >= thr_of(code)) ? 1 : 0);
                if (n < DEPTH) push(8'(n));
            end
            push(8'h55);
            check("R9 overrun in sweep", overrun, 1);
        end
        fcr_write(8'h03);
        check("R3 level cleared", level, 0);
        check("R3 dr cleared", data_ready, 0);
        check("R3 overrun cleared", overrun, 0);

        // R10: ticks sweep after a push
        for (int t = 0; t <= 5; t++) begin
            fcr_write(8'h03);
            push(8'hA5);
            ticks(t);
            check($sformatf("R10 pend after %0d ticks", t), timeout_pend, (t >= 4) ? 1 : 0);
        end
        rd(got);
        check("R11 read clears pend", timeout_pend, 0);
        check("R11 read data", got, 8'hA5);

        // R10 restart by push
        push(8'h01);
        ticks(3);
        push(8'h02);
        ticks(3);
        check("R10 push restart holds", timeout_pend, 0);
        ticks(1);
        check("R10 push restart expiry", timeout_pend, 1);
        rd(got);
        check("R11 partial read clears", timeout_pend, 0);
        ticks(3);
        check("R10 read restart holds", timeout_pend, 0);
        ticks(1);
        check("R10 read restart expiry", timeout_pend, 1);
        rd(got);
        check("R11 emptying read clears", timeout_pend, 0);

        // R12: emptying read stops timer
        push(8'h07);
        ticks(2);
        rd(got);
        ticks(6);
        check("R12 no timeout after empty", timeout_pend, 0);

        // R10: tick coincident with push not counted
        push_tick(8'h09);
        ticks(3);
        check("R10 coincident tick ignored", timeout_pend, 0);
        ticks(1);
        check("R10 expiry after coincident", timeout_pend, 1);
        fcr_write(8'h03);
        check("R11 flush clears pend", timeout_pend, 0);

        // R11: an empty read clears pend too
        push(8'h0A);
        ticks(4);
        check("R10 pend set again", timeout_pend, 1);
        rd(got);
        rd(got);
        check("R11 empty read pend", timeout_pend, 0);

        // R8: break
        brk_event = 1'b1;
        step();
        brk_event = 1'b0;
        check("R8 break level", level, 1);
        check("R8 break flag", brk_flag, 1);
        check("R8 break dr", data_ready, 1);
        rd(got);
        check("R8 break byte", got, 0);
        check("R8 break cleared on empty", brk_flag, 0);
        brk_event = 1'b1;
        step();
        brk_event = 1'b0;
        do_lsr();
        check("R8 lsr clears break", brk_flag, 0);
        check("R8 dr stays", data_ready, 1);
        rd(got);

        // R6: disabled single-byte mode
        fcr_write(8'h00);
        check("R2 iir bits off", iir_fifo_bits, 0);
        check("R4 toggle tx pulse", tx_rst_pulse, 1);
        push(8'h11);
        check("R6 level one", level, 1);
        check("R5 disabled trig", trig_hit, 1);
        push(8'h22);
        check("R6 second push overrun", overrun, 1);
        check("R6 level still one", level, 1);
        ticks(6);
        check("R11 disabled no pend", timeout_pend, 0);
        rd(got);
        check("R6 held byte", got, 8'h11);
        check("R5 disabled trig low", trig_hit, 0);
        do_lsr();

        // R4: tx flush leaves rx alone; toggle flushes rx
        push(8'h33);
        fcr_write(8'h04);
        check("R4 tx pulse bit2", tx_rst_pulse, 1);
        check("R4 rx untouched", level, 1);
        fcr_write(8'h01);
        check("R4 toggle flushes rx", level, 0);
        check("R4 toggle pulse", tx_rst_pulse, 1);
        check("R2 enable iir", iir_fifo_bits, 3);

        finish_run();
    end

endmodule